// File: doc/BRIEF.md
# Time-Multiplexed Rule Weight Decoder

This block produces the firing strength of every rule in a sixteen-rule, two-input fuzzy controller. Each input arrives already fuzzified as a trapezoid of four ordered points on a 64-step universe. Each rule has one antecedent trapezoid per input. For each rule, the block measures how well each input matches its antecedent. The match is the height at which the two trapezoids intersect, quantised to a 4-bit grade. The smaller of the two grades becomes the rule's weight.

Each weight decoder contains a pair of matching units that run side by side, one per input. Each decoder serves four rules in turn, and each rule takes two cycles. In the first cycle the unit picks the overlap case and its operands. In the second cycle it divides and takes the minimum. Four such decoders work in parallel. Decoder i owns rules 4i to 4i+3. An eight-cycle stage runs without pause after reset. At the end of each stage all sixteen weights are published at once, together with a one-cycle valid pulse. The antecedent tables are plain inputs. The fuzzified inputs and the tables must stay steady over a stage.

Top module: `fzw_weight_decoder`

## Requirements
- R1: While reset is asserted, every weight field reads 0 and `weights_valid` is low.
- R2: If two trapezoids (p1<=p2<=p3<=p4) overlap in their supports and max(p2 of each) <= min(p3 of each), the matching degree is 15.
- R3: If one support ends at or before the other begins (a4 <= x1 or x4 <= a1), the matching degree is 0.
- R4: Otherwise, if the antecedent plateau lies left of the input plateau (a3 < x2), the degree is floor(15*(a4-x1) / ((a4-a3)+(x2-x1))).
- R5: In the remaining overlapping case (x3 < a2), the degree is floor(15*(x4-a1) / ((x4-x3)+(a2-a1))).
- R6: A rule's weight is the minimum of its two matching degrees: input A against antecedent A, and input B against antecedent B.
- R7: A stage lasts 8 cycles. `weights_valid` is high for exactly one cycle per stage. The first pulse follows the 8th rising edge after reset is released, and later pulses follow every 8 edges after that.
- R8: All weight fields change only in the cycle that `weights_valid` is high. Between pulses they hold their value.
- R9: Trapezoid points are 6 bits, packed with p1 in the lowest bits and rising toward p4. Rule r's antecedents sit at bits [24r+23:24r] of each table. Rule r's weight sits at bits [4r+3:4r] of `weights`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fin_a | input | 24 | Fuzzified trapezoid of input A |
| fin_b | input | 24 | Fuzzified trapezoid of input B |
| ant_a | input | 384 | Antecedent trapezoids for input A, 16 rules |
| ant_b | input | 384 | Antecedent trapezoids for input B, 16 rules |
| weights | output | 64 | Published rule weights, 4 bits per rule |
| weights_valid | output | 1 | One-cycle pulse when new weights are published |

## Verification
The first stage uses a hand-built vector. In it, the rules that matter pair one input with an identical, a disjoint, a left-crossing and a right-crossing antecedent. This separates the four overlap cases, and a wrong case choice or a swapped crossing formula shows up as a wrong grade. The later stages use random sorted trapezoids, including collapsed ones where points coincide. These test the min of two different degrees and the exact floor of the division. Because each rule has its own weight field, they also catch any wrong mapping of a rule to its decoder, slot or field. Between pulses the weights are compared with the last published set, and the spacing between pulses is measured. Together these catch a wrong stage length and any early or partial update.

// File: rtl/fzw_pkg.sv
package fzw_pkg;
  // Overlap case of two trapezoids, picked in the first cycle of a rule.
  typedef enum logic [1:0] {
    OV_NONE  = 2'd0,
    OV_LEFT  = 2'd1,
    OV_RIGHT = 2'd2,
    OV_FULL  = 2'd3
  } ov_kind_e;
endpackage

// File: rtl/fzw_match_unit.sv
module fzw_match_unit
  import fzw_pkg::*;
#(
  parameter int PW = 6,
  parameter int GW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [4*PW-1:0] ant,
  input  logic [4*PW-1:0] fin,
  output logic [GW-1:0]   grade
);
  localparam int DW = PW + 1;
  localparam int XW = PW + GW + 1;
  localparam logic [GW-1:0] GMAX = '1;

  typedef logic [PW-1:0] pt_t;

  function automatic ov_kind_e classify(pt_t a1, pt_t a2, pt_t a3, pt_t a4,
                                        pt_t x1, pt_t x2, pt_t x3, pt_t x4);
    pt_t lo, hi;
    lo = (a2 > x2) ? a2 : x2;
    hi = (a3 < x3) ? a3 : x3;
    if (a4 <= x1 || x4 <= a1) return OV_NONE;
    if (lo <= hi)             return OV_FULL;
    if (a3 < x2)              return OV_LEFT;
    return OV_RIGHT;
  endfunction

  function automatic logic [GW-1:0] cross_grade(logic [PW-1:0] num, logic [DW-1:0] den);
    logic [XW-1:0] prod, quo;
    if (den == '0) return '0;
    prod = XW'(num) * XW'(GMAX);
    quo  = prod / XW'(den);
    return quo[GW-1:0];
  endfunction

  pt_t a1, a2, a3, a4, x1, x2, x3, x4;
  assign {a4, a3, a2, a1} = ant;
  assign {x4, x3, x2, x1} = fin;

  ov_kind_e      kind_d, kind_q;
  logic [PW-1:0] num_d, num_q;
  logic [DW-1:0] den_d, den_q;

  always_comb begin
    kind_d = classify(a1, a2, a3, a4, x1, x2, x3, x4);
    num_d  = '0;
    den_d  = '0;
    if (kind_d == OV_LEFT) begin
      num_d = a4 - x1;
      den_d = DW'(a4 - a3) + DW'(x2 - x1);
    end else if (kind_d == OV_RIGHT) begin
      num_d = x4 - a1;
      den_d = DW'(x4 - x3) + DW'(a2 - a1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= OV_NONE;
      num_q  <= '0;
      den_q  <= '0;
    end else if (load) begin
      kind_q <= kind_d;
      num_q  <= num_d;
      den_q  <= den_d;
    end
  end

  always_comb begin
    unique case (kind_q)
      OV_FULL:           grade = GMAX;
      OV_LEFT, OV_RIGHT: grade = cross_grade(num_q, den_q);
      default:           grade = '0;
    endcase
  end

  // Named events for the checks below.
  logic disjoint_w, core_w, left_w;
  assign disjoint_w = (a4 <= x1) || (x4 <= a1);
  assign core_w     = !disjoint_w && (((a2 > x2) ? a2 : x2) <= ((a3 < x3) ? a3 : x3));
  assign left_w     = !disjoint_w && !core_w && (a3 < x2);

  a_r3_disjoint_zero: assert property (@(posedge clk) disable iff (!rst_n)
    load && disjoint_w |=> grade == '0);
  a_r2_core_full: assert property (@(posedge clk) disable iff (!rst_n)
    load && core_w |=> grade == GMAX);
  a_r4_cross_below_full: assert property (@(posedge clk) disable iff (!rst_n)
    load && left_w |=> grade != GMAX);
endmodule

// File: rtl/fzw_rule_decoder.sv
module fzw_rule_decoder #(
  parameter int PW  = 6,
  parameter int GW  = 4,
  parameter int RPD = 4,                 // power of two, at least 2
  parameter int CW  = $clog2(2*RPD)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [CW-1:0]         cnt,
  input  logic [4*PW-1:0]       fin_a,
  input  logic [4*PW-1:0]       fin_b,
  input  logic [RPD*4*PW-1:0]   ant_a,
  input  logic [RPD*4*PW-1:0]   ant_b,
  output logic [RPD*GW-1:0]     wt_out
);
  localparam int QW = 4 * PW;
  localparam int SW = CW - 1;

  logic [SW-1:0] sel;
  logic          load, last;
  assign sel  = cnt[CW-1:1];
  assign load = ~cnt[0];
  assign last = (cnt == CW'(2*RPD-1));

  // Input multiplexers: one antecedent per input for the slot in turn.
  logic [QW-1:0] ant_a_sel, ant_b_sel;
  assign ant_a_sel = ant_a[sel*QW +: QW];
  assign ant_b_sel = ant_b[sel*QW +: QW];

  logic [GW-1:0] grade_a, grade_b, wt_new;

  fzw_match_unit #(.PW(PW), .GW(GW)) u_match_a (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ant(ant_a_sel), .fin(fin_a), .grade(grade_a));

  fzw_match_unit #(.PW(PW), .GW(GW)) u_match_b (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ant(ant_b_sel), .fin(fin_b), .grade(grade_b));

  assign wt_new = (grade_a < grade_b) ? grade_a : grade_b;

  // Output demultiplexer into per-slot shadow registers, then publish.
  logic [GW-1:0] shadow  [RPD];
  logic [GW-1:0] wt_pub  [RPD];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < RPD; k++) begin
        shadow[k] <= '0;
        wt_pub[k] <= '0;
      end
    end else begin
      if (cnt[0]) shadow[sel] <= wt_new;
      if (last) begin
        for (int k = 0; k < RPD; k++)
          wt_pub[k] <= (SW'(k) == sel) ? wt_new : shadow[k];
      end
    end
  end

  always_comb begin
    for (int k = 0; k < RPD; k++) wt_out[k*GW +: GW] = wt_pub[k];
  end

  a_r6_weight_is_min: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] |-> (wt_new <= grade_a) && (wt_new <= grade_b) &&
               ((wt_new == grade_a) || (wt_new == grade_b)));
endmodule

// File: rtl/fzw_weight_decoder.sv
module fzw_weight_decoder #(
  parameter int PW   = 6,
  parameter int GW   = 4,
  parameter int NDEC = 4,
  parameter int RPD  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [4*PW-1:0]         fin_a,
  input  logic [4*PW-1:0]         fin_b,
  input  logic [NDEC*RPD*4*PW-1:0] ant_a,
  input  logic [NDEC*RPD*4*PW-1:0] ant_b,
  output logic [NDEC*RPD*GW-1:0]  weights,
  output logic                    weights_valid
);
  localparam int CW   = $clog2(2*RPD);
  localparam int DAW  = RPD * 4 * PW;
  localparam int DWW  = RPD * GW;
  localparam logic [CW-1:0] LAST = CW'(2*RPD-1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      weights_valid <= 1'b0;
    end else begin
      cnt           <= (cnt == LAST) ? '0 : cnt + 1'b1;
      weights_valid <= (cnt == LAST);
    end
  end

  for (genvar i = 0; i < NDEC; i++) begin : g_dec
    fzw_rule_decoder #(.PW(PW), .GW(GW), .RPD(RPD), .CW(CW)) u_dec (
      .clk(clk), .rst_n(rst_n), .cnt(cnt),
      .fin_a(fin_a), .fin_b(fin_b),
      .ant_a(ant_a[i*DAW +: DAW]), .ant_b(ant_b[i*DAW +: DAW]),
      .wt_out(weights[i*DWW +: DWW]));
  end

  a_r7_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    weights_valid |=> !weights_valid);
  a_r7_valid_stage_start: assert property (@(posedge clk) disable iff (!rst_n)
    weights_valid |-> cnt == '0);
  a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !weights_valid |-> $stable(weights));
endmodule

// File: tb/sim_fzw_weight_decoder.sv
module sim_fzw_weight_decoder;
  localparam int NR = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [23:0]  fin_a = '0, fin_b = '0;
  logic [383:0] ant_a = '0, ant_b = '0;
  logic [63:0]  weights;
  logic         weights_valid;

  typedef struct { logic [23:0] fa, fb; logic [383:0] aa, ab; } vec_t;
  vec_t vq[$];

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fzw_weight_decoder u0 (.clk(clk), .rst_n(rst_n), .fin_a(fin_a), .fin_b(fin_b),
                         .ant_a(ant_a), .ant_b(ant_b),
                         .weights(weights), .weights_valid(weights_valid));

  // Reference degree, written from the requirement text.
  function automatic int deg(logic [23:0] a, logic [23:0] x);
    int a1 = a[5:0], a2 = a[11:6], a3 = a[17:12], a4 = a[23:18];
    int x1 = x[5:0], x2 = x[11:6], x3 = x[17:12], x4 = x[23:18];
    if (a4 <= x1 || x4 <= a1) return 0;                                  // R3
    if ((a2 > x2 ? a2 : x2) <= (a3 < x3 ? a3 : x3)) return 15;           // R2
    if (a3 < x2) return (15 * (a4 - x1)) / ((a4 - a3) + (x2 - x1));      // R4
    return (15 * (x4 - a1)) / ((x4 - x3) + (a2 - a1));                   // R5
  endfunction

  function automatic string tag(logic [23:0] a, logic [23:0] x);
    int a1 = a[5:0], a2 = a[11:6], a3 = a[17:12], a4 = a[23:18];
    int x1 = x[5:0], x2 = x[11:6], x3 = x[17:12], x4 = x[23:18];
    if (a4 <= x1 || x4 <= a1) return "R3";
    if ((a2 > x2 ? a2 : x2) <= (a3 < x3 ? a3 : x3)) return "R2";
    if (a3 < x2) return "R4";
    return "R5";
  endfunction

  function automatic logic [23:0] trap(int p1, int p2, int p3, int p4);
    return {6'(p4), 6'(p3), 6'(p2), 6'(p1)};
  endfunction

  function automatic logic [23:0] rnd_trap();
    int v[4];
    int t;
    for (int i = 0; i < 4; i++) v[i] = $urandom_range(0, 63);
    if ($urandom_range(0, 3) == 0) v[2] = v[1];
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3 - i; j++)
        if (v[j] > v[j+1]) begin t = v[j]; v[j] = v[j+1]; v[j+1] = t; end
    return trap(v[0], v[1], v[2], v[3]);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Driver: push the item, then present it for one stage.
  task automatic drive(vec_t v);
    vq.push_back(v);
    fin_a = v.fa; fin_b = v.fb; ant_a = v.aa; ant_b = v.ab;
  endtask

  task automatic wait_pulse();
    do begin @(posedge clk); #1; end while (!weights_valid);
  endtask

  initial begin
    vec_t v;
    // Directed stage: identical, disjoint, left and right crossings.
    v.fa = trap(10, 20, 30, 40);
    v.fb = trap(10, 20, 30, 40);
    for (int r = 0; r < NR; r++) begin
      v.aa[r*24 +: 24] = rnd_trap();
      v.ab[r*24 +: 24] = rnd_trap();
    end
    v.aa[0*24 +: 24] = trap(10, 20, 30, 40); v.ab[0*24 +: 24] = trap(10, 20, 30, 40); // 15, R2
    v.aa[5*24 +: 24] = trap(50, 55, 60, 63); v.ab[5*24 +: 24] = trap(10, 20, 30, 40); // 0,  R3
    v.aa[10*24 +: 24] = trap(0, 5, 12, 18);  v.ab[10*24 +: 24] = trap(10, 20, 30, 40); // 7,  R4
    v.aa[15*24 +: 24] = trap(35, 45, 50, 60); v.ab[15*24 +: 24] = trap(10, 20, 30, 40); // 3, R5
    drive(v);
    #20;
    check(weights == '0, "R1 weights in reset", int'(weights != '0), 0);
    check(weights_valid == 1'b0, "R1 valid in reset", int'(weights_valid), 0);
    check(deg(v.aa[10*24 +: 24], v.fa) == 7, "R4 reference", deg(v.aa[10*24 +: 24], v.fa), 7);
    @(negedge clk); rst_n = 1'b1;
    for (int n = 0; n < 24; n++) begin
      wait_pulse();
      v.fa = rnd_trap(); v.fb = rnd_trap();
      for (int r = 0; r < NR; r++) begin
        v.aa[r*24 +: 24] = rnd_trap();
        v.ab[r*24 +: 24] = rnd_trap();
      end
      drive(v);
    end
    wait_pulse();
    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end

  // Monitor: pops the expected item at each pulse, checks holds between pulses.
  initial begin
    int cyc = 0, last_pulse = 0;
    logic [63:0] last_pub = '0;
    forever begin
      @(posedge clk); #2;
      if (rst_n) begin
        cyc++;
        if (weights_valid) begin
          check(cyc - last_pulse == 8, "R7 stage length", cyc - last_pulse, 8);
          last_pulse = cyc;
          if (vq.size() == 0) begin
            check(0, "R7 pulse without stage", 0, 1);
          end else begin
            vec_t e;
            e = vq.pop_front();
            for (int r = 0; r < NR; r++) begin
              int da, db, ex, ac;
              da = deg(e.aa[r*24 +: 24], e.fa);
              db = deg(e.ab[r*24 +: 24], e.fb);
              ex = (da < db) ? da : db;
              ac = int'(weights[r*4 +: 4]);
              check(ac == ex,
                    $sformatf("R6 R9 rule %0d (%s/%s)", r,
                              tag(e.aa[r*24 +: 24], e.fa), tag(e.ab[r*24 +: 24], e.fb)),
                    ac, ex);
            end
          end
          last_pub = weights;
        end else begin
          check(weights == last_pub, "R8 hold between pulses",
                int'(weights != last_pub), 0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      finish_run();
    end
  end
endmodule